// File: doc/BRIEF.md
# Successive-Approximation Divider

This block computes the truncated ratio of two unsigned 16-bit numbers for the ratio stage of a fast control loop. It does not shift and subtract. It builds the quotient one bit at a time, starting at the most significant bit. On each cycle it sets the next bit in a trial quotient, multiplies the trial by the divisor, and keeps the bit only if the product does not exceed the dividend. A complete divide therefore takes one cycle per quotient bit. The block handles one request at a time and never overlaps two requests.

Inputs that change slowly can use a second mode. When tracking is requested and an earlier divide has left a valid quotient, the block does not start over. Each request moves the stored quotient one step toward the exact floor ratio of the current operands. It does this by comparing q·D and (q+1)·D against the dividend. If the request is held high, a new result comes out on every cycle.

A zero divisor is answered at once with an all-ones quotient and a one-cycle divide-by-zero flag.

Top module: `sa_divider`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, `done_o` and `dz_o` are 0 and `quot_o` is 0.
- R2: A full divide with divisor D ≠ 0 yields floor(N/D). If the request is sampled at clock edge k, `done_o` is high for exactly the one cycle after edge k+16 and stays low from edge k+1 through edge k+15.
- R3: During a full divide, `quot_o` keeps its earlier value and `done_o` stays low until the final bit has been decided.
- R4: A request with divisor 0 (full or tracking) drives `quot_o` to 16'hFFFF and raises both `dz_o` and `done_o` for the single cycle after the accepting edge. It also discards the tracking seed.
- R5: A tracking request (`track_i`=1) with a valid seed q sets `quot_o` in the next cycle to q+1 if q < floor(N/D), to q−1 if q > floor(N/D), and leaves it at q otherwise. The result never leaves the range 0…16'hFFFF.
- R6: A tracking request with no valid seed, either after reset or after a divide by zero, runs as a full divide with full-divide timing.
- R7: A request that arrives while a full divide is running is ignored. The running divide still returns its own result, and no extra `done_o` follows.
- R8: The extreme operands are handled exactly: N=16'hFFFF with D=1 gives 16'hFFFF, N<D gives 0, and N=D gives 1.
- R9: If a tracking request is held high, `done_o` is asserted on every cycle and each cycle produces a new one-step result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request strobe, sampled only while no full divide is running |
| track_i | input | 1 | Selects a one-step tracking update instead of a full divide |
| dividend_i | input | 16 | Unsigned dividend N |
| divisor_i | input | 16 | Unsigned divisor D |
| quot_o | output | 16 | Registered quotient, also the tracking seed |
| done_o | output | 1 | One-cycle result-valid strobe |
| dz_o | output | 1 | Divide-by-zero flag, high together with `done_o` |

## Verification
On every cycle, the bound checker confirms four things. Each finished full divide meets the floor bounds for the operands it captured. A tracking result never moves more than one step. The quotient stays frozen while bits are still being decided. A zero-divisor flag always comes with an all-ones, valid result.

Some behaviours can only be shown by the bench's scenarios, because they depend on sequences of requests:
- the exact 16-cycle completion edge;
- a request that is ignored in the middle of a divide;
- the fall back to a full divide when no seed exists;
- saturation at both ends of the range;
- convergence over several held tracking cycles.

// File: rtl/sad_pkg.sv
package sad_pkg;
  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } sad_state_e;
endpackage

// File: rtl/sad_mul_cmp.sv
// One trial lane: multiplies a factor by the divisor and reports whether the
// product still fits under the dividend. The product is as wide as both
// operands combined, so the compare cannot wrap.
module sad_mul_cmp #(
  parameter int OPW = 17,
  parameter int DW  = 16
) (
  input  logic [OPW-1:0] fac_i,
  input  logic [DW-1:0]  div_i,
  input  logic [DW-1:0]  dvd_i,
  output logic           fits_o
);
  localparam int PW = OPW + DW;

  logic [PW-1:0] prod;

  assign prod   = PW'(fac_i) * PW'(div_i);
  assign fits_o = (prod <= PW'(dvd_i));
endmodule

// File: rtl/sad_bit_walker.sv
// One-hot pointer to the quotient bit being decided, walking from the most
// significant bit down to the least significant bit.
module sad_bit_walker #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load_i,
  input  logic         step_i,
  output logic [W-1:0] msk_o,
  output logic         last_o
);
  localparam logic [W-1:0] TOP_BIT = {1'b1, {(W-1){1'b0}}};

  always_ff @(posedge clk) begin
    if (rst) begin
      msk_o <= '0;
    end else if (load_i) begin
      msk_o <= TOP_BIT;
    end else if (step_i) begin
      msk_o <= msk_o >> 1;
    end
  end

  assign last_o = msk_o[0];
endmodule

// File: rtl/sad_track_step.sv
// Moves the quotient one step toward floor(N/D), using the results of the two
// product comparisons (q*D <= N and (q+1)*D <= N). The result stays in range.
module sad_track_step #(
  parameter int W = 16
) (
  input  logic [W-1:0] q_i,
  input  logic         fit_lo_i,
  input  logic         fit_hi_i,
  output logic [W-1:0] q_o
);
  always_comb begin
    q_o = q_i;
    if (!fit_lo_i) begin
      if (q_i != '0) q_o = q_i - W'(1);
    end else if (fit_hi_i) begin
      if (q_i != '1) q_o = q_i + W'(1);
    end
  end
endmodule

// File: rtl/sa_divider.sv
module sa_divider
  import sad_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start_i,
  input  logic         track_i,
  input  logic [W-1:0] dividend_i,
  input  logic [W-1:0] divisor_i,
  output logic [W-1:0] quot_o,
  output logic         done_o,
  output logic         dz_o
);
  localparam int LANES = 2;
  localparam int FW    = W + 1;

  sad_state_e   state;
  logic         busy;
  logic         seeded;
  logic [W-1:0] acc_q;
  logic [W-1:0] opd_n;
  logic [W-1:0] opd_d;
  logic [W-1:0] walk_msk;
  logic         walk_last;
  logic [W-1:0] trial_q;
  logic [W-1:0] trk_next;
  logic         div_zero;
  logic         take_trk;
  logic         accept;
  logic         begin_full;

  logic [FW-1:0] lane_fac [LANES];
  logic [W-1:0]  lane_div [LANES];
  logic [W-1:0]  lane_dvd [LANES];
  logic          lane_fit [LANES];

  assign busy       = (state == ST_RUN);
  assign accept     = start_i && !busy;
  assign div_zero   = (divisor_i == '0);
  assign take_trk   = track_i && seeded;
  assign begin_full = accept && !div_zero && !take_trk;
  assign trial_q    = acc_q | walk_msk;

  sad_bit_walker #(.W(W)) u_walk (
    .clk    (clk),
    .rst    (rst),
    .load_i (begin_full),
    .step_i (busy),
    .msk_o  (walk_msk),
    .last_o (walk_last)
  );

  // Lane 0 tests the trial quotient while a divide runs, and q while tracking.
  // Lane 1 tests q+1 and is only needed for tracking.
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    if (l == 0) begin : g_primary
      assign lane_fac[l] = busy ? {1'b0, trial_q} : {1'b0, quot_o};
      assign lane_div[l] = busy ? opd_d : divisor_i;
      assign lane_dvd[l] = busy ? opd_n : dividend_i;
    end else begin : g_upper
      assign lane_fac[l] = {1'b0, quot_o} + FW'(1);
      assign lane_div[l] = divisor_i;
      assign lane_dvd[l] = dividend_i;
    end
    sad_mul_cmp #(.OPW(FW), .DW(W)) u_mc (
      .fac_i  (lane_fac[l]),
      .div_i  (lane_div[l]),
      .dvd_i  (lane_dvd[l]),
      .fits_o (lane_fit[l])
    );
  end

  sad_track_step #(.W(W)) u_trk (
    .q_i      (quot_o),
    .fit_lo_i (lane_fit[0]),
    .fit_hi_i (lane_fit[1]),
    .q_o      (trk_next)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      seeded <= 1'b0;
      acc_q  <= '0;
      opd_n  <= '0;
      opd_d  <= '0;
      quot_o <= '0;
      done_o <= 1'b0;
      dz_o   <= 1'b0;
    end else begin
      done_o <= 1'b0;
      dz_o   <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start_i) begin
            if (div_zero) begin
              quot_o <= '1;
              dz_o   <= 1'b1;
              done_o <= 1'b1;
              seeded <= 1'b0;
            end else if (take_trk) begin
              quot_o <= trk_next;
              done_o <= 1'b1;
            end else begin
              opd_n <= dividend_i;
              opd_d <= divisor_i;
              acc_q <= '0;
              state <= ST_RUN;
            end
          end
        end
        ST_RUN: begin
          if (lane_fit[0]) acc_q <= trial_q;
          if (walk_last) begin
            quot_o <= lane_fit[0] ? trial_q : acc_q;
            done_o <= 1'b1;
            seeded <= 1'b1;
            state  <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sad_checker.sv
module sad_checker #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst,
  input logic         start_i,
  input logic         track_i,
  input logic [W-1:0] dividend_i,
  input logic [W-1:0] divisor_i,
  input logic [W-1:0] quot_o,
  input logic         done_o,
  input logic         dz_o,
  input logic         busy,
  input logic         seeded,
  input logic         walk_last
);
  localparam int PW = 2 * W + 1;

  logic         pend_full;
  logic         pend_trk;
  logic [W-1:0] cap_n;
  logic [W-1:0] cap_d;
  logic         acc;
  logic         nz;
  logic [PW-1:0] lo_p;
  logic [PW-1:0] hi_p;

  assign acc  = start_i && !busy;
  assign nz   = (divisor_i != '0);
  assign lo_p = PW'(quot_o) * PW'(cap_d);
  assign hi_p = (PW'(quot_o) + PW'(1)) * PW'(cap_d);

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_full <= 1'b0;
      pend_trk  <= 1'b0;
      cap_n     <= '0;
      cap_d     <= '0;
    end else begin
      pend_trk <= acc && nz && track_i && seeded;
      if (acc && nz && !(track_i && seeded)) begin
        pend_full <= 1'b1;
        cap_n     <= dividend_i;
        cap_d     <= divisor_i;
      end else if (done_o) begin
        pend_full <= 1'b0;
      end
    end
  end

  // R2: a finished full divide returns the floor ratio of the captured operands
  a_r2_floor_result: assert property (@(posedge clk) disable iff (rst)
    (done_o && pend_full) |-> (lo_p <= PW'(cap_n)) && (hi_p > PW'(cap_n)));

  // R3: the quotient is frozen until the last bit is decided
  a_r3_hold_while_running: assert property (@(posedge clk) disable iff (rst)
    (busy && !walk_last) |=> ($stable(quot_o) && !done_o));

  // R4: a divide-by-zero flag always comes with an all-ones, valid result
  a_r4_zero_all_ones: assert property (@(posedge clk) disable iff (rst)
    dz_o |-> (done_o && (quot_o == {W{1'b1}})));

  // R5: a tracking update moves the quotient by at most one step
  a_r5_track_single_step: assert property (@(posedge clk) disable iff (rst)
    pend_trk |-> (done_o &&
      ((W'(quot_o - $past(quot_o)) <= W'(1)) ||
       (W'(quot_o - $past(quot_o)) == {W{1'b1}}))));

  // R9: a result is only reported after a request or at the end of a divide
  a_r9_done_has_cause: assert property (@(posedge clk) disable iff (rst)
    done_o |-> ($past(start_i) || $past(busy)));
endmodule

bind sa_divider sad_checker #(.W(W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .start_i    (start_i),
  .track_i    (track_i),
  .dividend_i (dividend_i),
  .divisor_i  (divisor_i),
  .quot_o     (quot_o),
  .done_o     (done_o),
  .dz_o       (dz_o),
  .busy       (busy),
  .seeded     (seeded),
  .walk_last  (walk_last)
);

// File: tb/sim_sa_divider.sv
`timescale 1ns/1ps
module sim_sa_divider;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic        trk = 1'b0;
  logic [15:0] nval = '0;
  logic [15:0] dval = '0;
  logic [15:0] q;
  logic        done;
  logic        dz;

  int n_cmp = 0;
  int n_bad = 0;
  logic [15:0] qm = '0;

  localparam int NV = 10;
  // {dividend, divisor}; expected quotient is computed in the bench
  localparam logic [31:0] VEC [NV] = '{
    {16'd1000,  16'd10},
    {16'hFFFF,  16'd1},     // R8 top of range
    {16'd5,     16'd10},    // R8 N<D
    {16'hFFFF,  16'hFFFF},  // R8 N=D
    {16'd65534, 16'hFFFF},
    {16'd12345, 16'd7},
    {16'd40000, 16'd3},
    {16'd1,     16'd1},
    {16'd0,     16'd9},
    {16'hFFFF,  16'd256}
  };

  always #4 clk = ~clk;

  sa_divider #(.W(16)) u0 (
    .clk        (clk),
    .rst        (rst),
    .start_i    (start),
    .track_i    (trk),
    .dividend_i (nval),
    .divisor_i  (dval),
    .quot_o     (q),
    .done_o     (done),
    .dz_o       (dz)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  // full divide: request sampled at edge k, result expected after edge k+16
  task automatic run_full(input logic [15:0] n, input logic [15:0] d, input bit trkreq, input string tag);
    int early;
    early = 0;
    @(negedge clk);
    start = 1'b1; trk = trkreq; nval = n; dval = d;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0; trk = 1'b0;
    for (int j = 1; j < 16; j++) begin
      @(negedge clk);
      if (done) early++;
    end
    chk(early == 0, {tag, " R3 no early done"}, early, 0);
    @(negedge clk);
    chk(done === 1'b1 && dz === 1'b0, {tag, " R2 done at 16"}, {done, dz}, 2'b10);
    chk(q === n / d, {tag, " R2 quotient"}, q, n / d);
    qm = n / d;
    @(negedge clk);
    chk(done === 1'b0, {tag, " R9 done one cycle"}, done, 0);
  endtask

  // held tracking request; called at a negedge
  task automatic track_steps(input logic [15:0] n, input logic [15:0] d, input int steps, input string tag);
    logic [15:0] e;
    nval = n; dval = d; start = 1'b1; trk = 1'b1;
    e = n / d;
    for (int s = 0; s < steps; s++) begin
      @(negedge clk);
      if (qm < e) qm = qm + 16'd1;
      else if (qm > e) qm = qm - 16'd1;
      chk(done === 1'b1 && q === qm, {tag, " R5 R9 step"}, {done, q}, {1'b1, qm});
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(done === 1'b0 && dz === 1'b0 && q === 16'h0, "R1 in reset", {done, dz, q}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(done === 1'b0 && dz === 1'b0 && q === 16'h0, "R1 after reset", {done, dz, q}, 0);

    // R6: tracking request without a seed behaves as a full divide
    run_full(16'd777, 16'd7, 1'b1, "R6 unseeded");

    // R2, R8: vector table
    for (int i = 0; i < NV; i++) begin
      run_full(VEC[i][31:16], VEC[i][15:0], 1'b0, "R2 R8 table");
    end

    // R7: request during a running divide is ignored
    begin
      int extra;
      extra = 0;
      @(negedge clk);
      start = 1'b1; trk = 1'b0; nval = 16'd1000; dval = 16'd10;
      @(posedge clk);
      @(negedge clk);
      start = 1'b0;
      for (int j = 1; j < 16; j++) begin
        @(negedge clk);
        if (j == 5) begin start = 1'b1; nval = 16'd7; dval = 16'd1; end
        else start = 1'b0;
      end
      @(negedge clk);
      chk(done === 1'b1 && q === 16'd100, "R7 running divide result kept", q, 16'd100);
      for (int j = 0; j < 20; j++) begin
        @(negedge clk);
        if (done) extra++;
      end
      chk(extra == 0, "R7 no done from ignored request", extra, 0);
      chk(q === 16'd100, "R7 quotient untouched", q, 16'd100);
    end

    // R5, R9: tracking up, hold, then down
    run_full(16'd1000, 16'd10, 1'b0, "R5 seed");
    @(negedge clk);
    track_steps(16'd1030, 16'd10, 5, "R5 up");
    track_steps(16'd1000, 16'd10, 4, "R5 down");
    track_steps(16'd1000, 16'd8, 2, "R5 divisor change");
    start = 1'b0; trk = 1'b0;
    @(negedge clk);
    chk(done === 1'b0 && q === qm, "R9 stops when released", {done, q}, {1'b0, qm});

    // R5: saturation at top and bottom
    run_full(16'hFFFF, 16'd1, 1'b0, "R5 top seed");
    @(negedge clk);
    track_steps(16'hFFFF, 16'd1, 2, "R5 top hold");
    track_steps(16'hFFFE, 16'd1, 1, "R5 top down");
    start = 1'b0; trk = 1'b0;
    run_full(16'd5, 16'd10, 1'b0, "R5 bottom seed");
    @(negedge clk);
    track_steps(16'd3, 16'd10, 2, "R5 bottom hold");
    start = 1'b0; trk = 1'b0;

    // R4: zero divisor, then R6: seed discarded
    @(negedge clk);
    start = 1'b1; trk = 1'b1; nval = 16'd123; dval = 16'd0;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0; trk = 1'b0;
    chk(done === 1'b1 && dz === 1'b1 && q === 16'hFFFF, "R4 zero divisor", {done, dz, q}, {2'b11, 16'hFFFF});
    @(negedge clk);
    chk(done === 1'b0 && dz === 1'b0 && q === 16'hFFFF, "R4 flag one cycle", {done, dz, q}, {2'b00, 16'hFFFF});
    run_full(16'd50, 16'd5, 1'b1, "R6 after zero");

    summary();
    $finish;
  end
endmodule